// File: doc/BRIEF.md
# Disk Sector Header Record Reader

This block recovers the header record at the front of each disk sector from a double-frequency read channel. The data separator in the drive delivers one read-clock pulse per bit cell and a read-data level that is sampled at each pulse. Both lines are resynchronised into the system clock domain. The block then runs one fixed sequence per sector: a blind skip, a search for the sync pattern, and the capture of the header.

A sector-mark pulse starts the sequence. Received bits are first counted off for a fixed number of word times and their values are not used. After the skip, the block searches for the sync pattern one bit at a time and discards zero words as it goes. The sync pattern is fifteen zeros followed by a one. The next three 16-bit words are taken as two header words and a check word. The check word is compared with the two header words folded by XOR into a fixed seed. The header words, a completion flag and a checksum flag stay valid until the next sector mark.

Two error conditions are reported. A strict mode rejects any non-zero preamble word that arrives after the skip. A timeout flag records that a sector mark arrived while the block was still skipping or searching.

Top module: `hdr_rd_top`

## Requirements
- R1: After reset every output is 0 and the block is idle. Received bits have no effect until the first sector mark.
- R2: A sector-mark pulse restarts the sequence from any state. On the next clock edge it clears hdr_done, pre_err, csum_err and both header words.
- R3: After a sector mark, the first 21 word times (336 received bits) are ignored, whatever their content.
- R4: After the skip, the sync pattern 0x0001 is detected on the first received 1 that follows at least 15 received zeros. This can happen at any bit offset, so the sync need not fall on a word boundary. Zero words are discarded.
- R5: After sync, the next 32 bits form header word 0 and then header word 1, each MSB first. Both words and hdr_done=1 are presented after the 48th bit. A header word equal to 0x0001 is taken as data and does not restart the search.
- R6: The third word after sync is the check word. csum_err is set together with hdr_done when the check word differs from 0x0151 ^ word0 ^ word1.
- R7: A bit is the value of rd_data sampled when rd_clk rises. Its effect appears on the outputs at the third clk rising edge after rd_clk rises.
- R8: With strict_en=1, the hunt checks the 16-bit window at the end of every 16th bit counted from the end of the skip. If that window is non-zero and is not the sync pattern, the read aborts: pre_err=1, hdr_done stays 0, and bits are ignored until the next mark. With strict_en=0, such words are ignored.
- R9: A sector mark that arrives while the block is skipping or searching sets sync_timeout. A mark in any other state clears it. The value holds until the next mark.
- R10: After hdr_done or an abort, received bits have no effect on any output until the next sector mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_en | input | 1 | Reject non-zero preamble words after the skip |
| sector_mark | input | 1 | One-clock sector start pulse, synchronous to clk |
| rd_clk | input | 1 | Read-clock pulses from the data separator, asynchronous |
| rd_data | input | 1 | Read-data level, sampled on the rise of rd_clk |
| hdr_word0 | output | 16 | First captured header word |
| hdr_word1 | output | 16 | Second captured header word |
| hdr_done | output | 1 | Header record captured |
| csum_err | output | 1 | Check word mismatch (valid with hdr_done) |
| pre_err | output | 1 | Strict-mode preamble abort |
| sync_timeout | output | 1 | Previous search ended by a mark without sync |

## Verification
A skip counter that is off by even one bit moves the hunt window. The effect shows up one sector later, either as a missed sync, which raises the timeout at the next mark, or as header words shifted by one bit. A slip of the word position during the hunt surfaces only in strict mode, as a spurious or missing abort at a preamble boundary. A wrong accumulator or capture index shows up as a wrong header word or checksum flag, in the cycle after the 48th bit. The bench drives preambles of every alignment, garbage in the skip, and marks placed in each state, and compares every output on every clock.

// File: rtl/hdr_rd_pkg.sv
package hdr_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SKIP = 2'd1,
    ST_HUNT = 2'd2,
    ST_CAP  = 2'd3
  } hdr_st_e;
endpackage

// File: rtl/hdr_bit_sync.sv
module hdr_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_clk,
  input  logic rd_data,
  output logic bit_stb,
  output logic bit_val
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] dt_q;
  logic              ck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q    <= '0;
      dt_q    <= '0;
      ck_prev <= 1'b0;
    end else begin
      ck_q    <= {ck_q[STAGES-2:0], rd_clk};
      dt_q    <= {dt_q[STAGES-2:0], rd_data};
      ck_prev <= ck_q[STAGES-1];
    end
  end

  assign bit_stb = ck_q[STAGES-1] & ~ck_prev;
  assign bit_val = dt_q[STAGES-1];

  // R7: one strobe per rising read clock
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/hdr_shift_win.sv
module hdr_shift_win #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fill_ones,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] win_nx
);
  logic [W-1:0] win_q;

  assign win_nx = {win_q[W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst)            win_q <= '0;
    else if (fill_ones) win_q <= '1;
    else if (shift_en)  win_q <= win_nx;
  end
endmodule

// File: rtl/hdr_csum_acc.sv
module hdr_csum_acc #(
  parameter int         W    = 16,
  parameter logic [W-1:0] SEED = 16'h0151
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_ld,
  input  logic         fold_en,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (seed_ld) acc_q <= SEED;
    else if (fold_en) acc_q <= acc_q ^ word_in;
  end

  // R6: a fold never happens in the same cycle as a reseed
  a_r6_no_fold_on_seed: assert property (@(posedge clk) disable iff (rst)
    seed_ld |-> !fold_en);
endmodule

// File: rtl/hdr_rd_top.sv
module hdr_rd_top
  import hdr_rd_pkg::*;
#(
  parameter int           WORD_W     = 16,
  parameter int           SKIP_WORDS = 21,
  parameter int           SYNC_STG   = 2,
  parameter logic [15:0]  SYNC_PAT   = 16'h0001,
  parameter logic [15:0]  CSUM_SEED  = 16'h0151
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strict_en,
  input  logic              sector_mark,
  input  logic              rd_clk,
  input  logic              rd_data,
  output logic [WORD_W-1:0] hdr_word0,
  output logic [WORD_W-1:0] hdr_word1,
  output logic              hdr_done,
  output logic              csum_err,
  output logic              pre_err,
  output logic              sync_timeout
);
  localparam int POS_W     = $clog2(WORD_W);
  localparam int CAP_WORDS = 3;
  localparam int WRD_W     = $clog2((SKIP_WORDS > CAP_WORDS ? SKIP_WORDS : CAP_WORDS) + 1);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(WORD_W - 1);
  localparam logic [WRD_W-1:0] SKIP_LAST = WRD_W'(SKIP_WORDS - 1);
  localparam logic [WRD_W-1:0] CAP_LAST  = WRD_W'(CAP_WORDS - 1);

  hdr_st_e            state;
  logic [POS_W-1:0]   pos;
  logic [WRD_W-1:0]   wrd;
  logic [WORD_W-1:0]  w0_q, w1_q;
  logic               bit_stb, bit_val;
  logic [WORD_W-1:0]  win_nx;
  logic [WORD_W-1:0]  acc_q;
  logic               sync_hit, word_end, shift_en, fold_en;

  hdr_bit_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .rd_clk(rd_clk), .rd_data(rd_data),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  assign shift_en = bit_stb && !sector_mark &&
                    (state == ST_HUNT || state == ST_CAP);

  hdr_shift_win #(.W(WORD_W)) u_win (
    .clk(clk), .rst(rst), .fill_ones(sector_mark), .shift_en(shift_en),
    .bit_in(bit_val), .win_nx(win_nx)
  );

  assign word_end = (pos == POS_LAST);
  assign sync_hit = bit_stb && !sector_mark && state == ST_HUNT &&
                    win_nx == SYNC_PAT;
  assign fold_en  = bit_stb && !sector_mark && state == ST_CAP &&
                    word_end && wrd != CAP_LAST;

  hdr_csum_acc #(.W(WORD_W), .SEED(CSUM_SEED)) u_acc (
    .clk(clk), .rst(rst), .seed_ld(sync_hit), .fold_en(fold_en),
    .word_in(win_nx), .acc_q(acc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      pos          <= '0;
      wrd          <= '0;
      w0_q         <= '0;
      w1_q         <= '0;
      hdr_word0    <= '0;
      hdr_word1    <= '0;
      hdr_done     <= 1'b0;
      csum_err     <= 1'b0;
      pre_err      <= 1'b0;
      sync_timeout <= 1'b0;
    end else if (sector_mark) begin
      sync_timeout <= (state == ST_SKIP) || (state == ST_HUNT);
      state        <= ST_SKIP;
      pos          <= '0;
      wrd          <= '0;
      hdr_word0    <= '0;
      hdr_word1    <= '0;
      hdr_done     <= 1'b0;
      csum_err     <= 1'b0;
      pre_err      <= 1'b0;
    end else if (bit_stb) begin
      unique case (state)
        ST_SKIP: begin
          pos <= pos + 1'b1;
          if (word_end) begin
            pos <= '0;
            if (wrd == SKIP_LAST) begin
              state <= ST_HUNT;
              wrd   <= '0;
            end else begin
              wrd <= wrd + 1'b1;
            end
          end
        end
        ST_HUNT: begin
          pos <= pos + 1'b1;
          if (sync_hit) begin
            state <= ST_CAP;
            pos   <= '0;
            wrd   <= '0;
          end else if (strict_en && word_end && win_nx != '0) begin
            state   <= ST_IDLE;
            pre_err <= 1'b1;
          end
        end
        ST_CAP: begin
          pos <= pos + 1'b1;
          if (word_end) begin
            pos <= '0;
            wrd <= wrd + 1'b1;
            if (wrd == '0) w0_q <= win_nx;
            else if (wrd == WRD_W'(1)) w1_q <= win_nx;
            else begin
              hdr_word0 <= w0_q;
              hdr_word1 <= w1_q;
              csum_err  <= (win_nx != acc_q);
              hdr_done  <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R6: checksum flag only accompanies a completed header
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst)
    csum_err |-> hdr_done);
  // R8: an abort never reports a completed header
  a_r8_abort_not_done: assert property (@(posedge clk) disable iff (rst)
    pre_err |-> !hdr_done);
  // R2: mark clears the result flags
  a_r2_mark_clears: assert property (@(posedge clk) disable iff (rst)
    sector_mark |=> (!hdr_done && !pre_err && !csum_err));
  // R9: timeout changes only at a mark
  a_r9_timeout_on_mark: assert property (@(posedge clk) disable iff (rst)
    !$stable(sync_timeout) |-> $past(sector_mark));
  // R5: completion is caused by a received bit
  a_r5_done_from_bit: assert property (@(posedge clk) disable iff (rst)
    $rose(hdr_done) |-> $past(bit_stb));
  // R10: idle block holds its results
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !sector_mark) |=>
      ($stable(hdr_word0) && $stable(hdr_word1) && $stable(hdr_done)));
endmodule

// File: tb/hdr_rd_top_tb.sv
module hdr_rd_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strict_en = 1'b0;
  logic sector_mark = 1'b0;
  logic rd_clk = 1'b0;
  logic rd_data = 1'b0;
  logic [15:0] hdr_word0, hdr_word1;
  logic hdr_done, csum_err, pre_err, sync_timeout;

  always #10 clk = ~clk;

  hdr_rd_top dut_i (
    .clk(clk), .rst(rst), .strict_en(strict_en), .sector_mark(sector_mark),
    .rd_clk(rd_clk), .rd_data(rd_data), .hdr_word0(hdr_word0),
    .hdr_word1(hdr_word1), .hdr_done(hdr_done), .csum_err(csum_err),
    .pre_err(pre_err), .sync_timeout(sync_timeout)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 0;

  // behavioural reference: 0 idle, 1 skip, 2 hunt, 3 capture
  int m_st = 0, m_cnt = 0, m_wc = 0, m_k = 0;
  int m_win = 0, m_sh = 0, m_w0 = 0, m_w1 = 0;
  int e_w0 = 0, e_w1 = 0;
  bit e_done = 0, e_cerr = 0, e_perr = 0, e_to = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic void model_mark();
    e_to = (m_st == 1 || m_st == 2);
    e_done = 0; e_cerr = 0; e_perr = 0; e_w0 = 0; e_w1 = 0;
    m_st = 1; m_cnt = 0;
  endfunction

  function automatic void model_bit(input bit b);
    case (m_st)
      1: begin
        m_cnt++;
        if (m_cnt == 21 * 16) begin m_st = 2; m_win = 16'hFFFF; m_wc = 0; end
      end
      2: begin
        m_win = ((m_win << 1) | b) & 16'hFFFF;
        m_wc++;
        if (m_win == 1) begin m_st = 3; m_k = 0; m_sh = 0; end
        else if (strict_en && (m_wc % 16 == 0) && m_win != 0) begin
          m_st = 0; e_perr = 1;
        end
      end
      3: begin
        m_sh = ((m_sh << 1) | b) & 16'hFFFF;
        m_k++;
        if (m_k == 16) m_w0 = m_sh;
        else if (m_k == 32) m_w1 = m_sh;
        else if (m_k == 48) begin
          e_w0 = m_w0; e_w1 = m_w1; e_done = 1;
          e_cerr = (m_sh != (16'h0151 ^ m_w0 ^ m_w1));
          m_st = 0;
        end
      end
      default: ;
    endcase
  endfunction

  always @(negedge clk) if (cmp_on) begin
    chk("R5 hdr_word0", hdr_word0, e_w0);
    chk("R5 hdr_word1", hdr_word1, e_w1);
    chk("R5 hdr_done", hdr_done, e_done);
    chk("R6 csum_err", csum_err, e_cerr);
    chk("R8 pre_err", pre_err, e_perr);
    chk("R9 sync_timeout", sync_timeout, e_to);
  end

  task automatic send_bit(input bit b);
    @(negedge clk); rd_data = b; rd_clk = 1'b1;
    repeat (3) @(posedge clk);
    model_bit(b);            // R7: effect at third clk edge
    @(negedge clk); rd_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic mark();
    @(negedge clk); sector_mark = 1'b1;
    @(posedge clk); model_mark();
    @(negedge clk); sector_mark = 1'b0;
  endtask

  task automatic skip_part(input bit garbage);
    for (int i = 0; i < 21; i++)
      send_word(garbage ? 16'(16'hA5C3 ^ (i * 16'h1357)) : 16'h0000);
  endtask

  task automatic tail(input logic [15:0] a, b, c);
    send_word(16'h0001); send_word(a); send_word(b); send_word(c);
  endtask

  function automatic logic [15:0] ck(input logic [15:0] a, b);
    return 16'h0151 ^ a ^ b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0; cmp_on = 1;
    // R1: reset state, bits before any mark ignored
    chk("R1 reset done", hdr_done, 0);
    chk("R1 reset word0", hdr_word0, 0);
    send_word(16'h0001); send_word(16'h1234);
    chk("R1 idle ignores bits", hdr_done, 0);

    // R3/R4/R5/R6: clean sector, 13 zero preamble words
    mark(); skip_part(0);
    for (int i = 0; i < 13; i++) send_word(16'h0000);
    tail(16'h1A2B, 16'h3C4D, ck(16'h1A2B, 16'h3C4D));
    chk("R5 done clean", hdr_done, 1);
    chk("R5 word0 clean", hdr_word0, 16'h1A2B);
    chk("R6 no err clean", csum_err, 0);

    // R10: bits after done ignored
    send_word(16'h0001); send_word(16'hFFFF);
    chk("R10 word0 held", hdr_word0, 16'h1A2B);

    // R6: bad check word
    mark(); skip_part(0); send_word(0);
    tail(16'h00FF, 16'hF00F, 16'h0000);
    chk("R6 bad csum", csum_err, 1);

    // R3: garbage inside skip, strict on
    strict_en = 1'b1;
    mark(); skip_part(1); send_word(0);
    tail(16'hBEEF, 16'h0001, ck(16'hBEEF, 16'h0001));
    chk("R3 garbage skipped", hdr_done, 1);
    chk("R5 0x0001 as data", hdr_word1, 16'h0001);

    // R8: strict abort on non-zero preamble word
    mark(); skip_part(0); send_word(16'hC000);
    chk("R8 abort flag", pre_err, 1);
    tail(16'h1111, 16'h2222, ck(16'h1111, 16'h2222));
    chk("R8 no done after abort", hdr_done, 0);
    chk("R10 word0 after abort", hdr_word0, 0);

    // R8: same stream non-strict is accepted
    strict_en = 1'b0;
    mark(); skip_part(0); send_word(16'hC000); send_word(0);
    tail(16'h1111, 16'h2222, ck(16'h1111, 16'h2222));
    chk("R8 nonstrict done", hdr_done, 1);
    chk("R8 nonstrict no abort", pre_err, 0);

    // R4: sync at odd bit offset, strict on
    strict_en = 1'b1;
    mark(); skip_part(0); send_word(0);
    for (int i = 0; i < 5; i++) send_bit(0);
    tail(16'h5A5A, 16'hA5A5, ck(16'h5A5A, 16'hA5A5));
    chk("R4 offset word0", hdr_word0, 16'h5A5A);
    chk("R4 offset done", hdr_done, 1);

    // R9: mark during hunt -> timeout; sector still completes
    mark(); skip_part(0); send_word(0); send_word(0);
    mark();
    chk("R9 timeout set", sync_timeout, 1);
    skip_part(0);
    tail(16'h0F0F, 16'h7777, ck(16'h0F0F, 16'h7777));
    chk("R9 timeout held", sync_timeout, 1);
    chk("R9 later sector done", hdr_done, 1);

    // R2/R9: mark during capture clears flags, no timeout
    mark();
    chk("R2 clears done", hdr_done, 0);
    chk("R2 clears word0", hdr_word0, 0);
    skip_part(0); send_word(16'h0001); send_word(16'h4444);
    mark();
    chk("R9 no timeout in capture", sync_timeout, 0);
    skip_part(0);
    tail(16'h8001, 16'h0000, ck(16'h8001, 16'h0000));
    chk("R5 final done", hdr_done, 1);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule